// File: doc/BRIEF.md
# Dual-Clock FIFO with Rewind and Selectable Output Timing

The block buffers 18-bit words between two unrelated clocks. A producer pushes words on the write clock and a consumer takes them on the read clock; neither clock has to be the faster one. The storage depth is a power of two set by a parameter, 8192 words by default. Occupancy is reported through a write-side flag, a read-side flag, a half-full flag and two threshold flags whose offsets come from a separate offset block.

The timing style is latched while master reset is active. In standard style the consumer must raise the read enable to fetch each word, which appears one read-clock edge later. In fall-through style the oldest word is placed on the data outputs on its own, and the read enable consumes it. A partial reset empties the buffer while keeping the latched style. A rewind pulse moves the read position back to the first word stored since the last reset, so the same stream can be read out again. An output enable only switches the data outputs to high impedance.

Top module: `xfifo_rt`

## Requirements
- R1: After master reset in standard style: rd_flag = 1 (empty), wr_flag = 0 (not full), half_full = 0, almost_empty = 1, almost_full = 0.
- R2: Every accepted word is delivered exactly once and in write order, for any interleaving of reads and writes on the two clocks, in either style.
- R3: In standard style, rd_flag (1 = empty) falls on the second rising read-clock edge after the write-clock edge that stores a word into an empty buffer.
- R4: In fall-through style, rd_flag (1 = word valid on rd_data) rises together with the first word on the third rising read-clock edge after the storing write edge, with rd_en held low, and the word stays until rd_en consumes it.
- R5: wr_flag reads 1 when full in standard style and 1 when space remains in fall-through style; full means 2^AW words held. A write while full is dropped and leaves the stored contents unchanged.
- R6: A read while empty is dropped: the read position does not move, and the next word written is the next word read.
- R7: half_full is 1 exactly while the write side counts more than 2^(AW-1) words held.
- R8: almost_full is 1 while the write side counts at least 2^AW - af_off words; almost_empty is 1 while the read side counts at most ae_off words.
- R9: A one-cycle retx pulse on the read clock, with writes idle and at most 2^AW words written since the last reset, returns reading to the first word written since that reset; standard style shows not-empty at the next read edge, fall-through style shows the first word with rd_flag = 1 on the second read edge after the pulse.
- R10: Partial reset (prst_n low) empties the buffer and keeps the timing style latched at master reset.
- R11: The style is taken from fwft_sel while mrst_n is low (0 = standard, 1 = fall-through).
- R12: With out_en low, rd_data is high impedance; reads and read position still behave as with out_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock, unrelated to wr_clk |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, keeps style |
| fwft_sel | input | 1 | Style select sampled during master reset |
| wr_en | input | 1 | Write request on wr_clk |
| wr_data | input | 18 | Word to store |
| rd_en | input | 1 | Read request on rd_clk |
| retx | input | 1 | Rewind pulse on rd_clk |
| out_en | input | 1 | Data output enable |
| ae_off | input | AW | Almost-empty offset |
| af_off | input | AW | Almost-full offset |
| rd_data | output | 18 | Word read, high impedance when out_en is low |
| rd_flag | output | 1 | Empty (standard) or output valid (fall-through) |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than half the words held |
| almost_empty | output | 1 | Read-side count at or below ae_off |
| almost_full | output | 1 | Write-side count at or above depth minus af_off |

## Verification
A corrupted pointer or a badly converted synchronised pointer shows at the data outputs as a skipped, repeated or stale word on the very next read, and at the flags as an empty or full that never clears or clears too early, visible within two or three edges of the opposite clock. A wrong latched style inverts the meaning of both flags right after reset, and a broken rewind shows as the wrong word on the first read after the pulse, so the bench compares every word read against its own model and samples the flags at exact edge counts.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } tmode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xfifo_rst_sync.sv
`timescale 1ns/1ps
module xfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/xfifo_ram.sv
`timescale 1ns/1ps
module xfifo_ram #(
  parameter int AW = 13,
  parameter int DW = 18
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xfifo_wside.sv
`timescale 1ns/1ps
module xfifo_wside
  import xfifo_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          mode_in,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_a,
  input  logic [AW-1:0] af_off,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW:0]   wbin,
  output logic          full,
  output logic          hfull,
  output logic          afull,
  output logic          fwft
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;
  localparam logic [PW-1:0] HALF_P  = PW'(1) << (AW - 1);

  logic [PW-1:0] rs1_q, rs2_q, rbin_s, occ;
  logic [PW-1:0] wbin_q, wbin_d;
  tmode_e        mode_q;

  // two-flop synchroniser for the read pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= '0;
      rs2_q <= '0;
    end else begin
      rs1_q <= rgray_a;
      rs2_q <= rs1_q;
    end
  end

  // style is loaded while master reset is held
  always_ff @(posedge clk) begin
    if (!mrst_n) mode_q <= tmode_e'(mode_in);
  end

  assign fwft   = (mode_q == MODE_FWFT);
  assign rbin_s = PW'(gray2bin(32'(rs2_q)));
  assign occ    = wbin_q - rbin_s;
  assign full   = (occ == DEPTH_P);
  assign hfull  = (occ > HALF_P);
  assign afull  = (occ >= (DEPTH_P - PW'(af_off)));

  always_comb begin
    we     = wr_en & ~full;
    wbin_d = wbin_q;
    if (we) wbin_d = wbin_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
    end else begin
      wbin_q <= wbin_d;
      wgray  <= PW'(bin2gray(32'(wbin_d)));
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wbin  = wbin_q;
endmodule

// File: rtl/xfifo_rside.sv
`timescale 1ns/1ps
module xfifo_rside
  import xfifo_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          mode_in,
  input  logic          rd_en,
  input  logic          retx,
  input  logic [AW:0]   wgray_a,
  input  logic [AW-1:0] ae_off,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   rbin,
  output logic          empty,
  output logic          ovalid,
  output logic          aempty,
  output logic          fwft
);
  localparam int PW = AW + 1;

  logic [PW-1:0] ws1_q, ws2_q, wbin_s, occ, occ_tot;
  logic [PW-1:0] rbin_q, rbin_d;
  logic          ov_q, ov_d;
  tmode_e        mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws1_q <= '0;
      ws2_q <= '0;
    end else begin
      ws1_q <= wgray_a;
      ws2_q <= ws1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) mode_q <= tmode_e'(mode_in);
  end

  assign fwft   = (mode_q == MODE_FWFT);
  assign wbin_s = PW'(gray2bin(32'(ws2_q)));
  assign occ    = wbin_s - rbin_q;
  assign empty  = (occ == '0);

  // next state: rewind wins, then prefetch or demand read
  always_comb begin
    re     = 1'b0;
    ov_d   = ov_q;
    rbin_d = rbin_q;
    if (retx) begin
      rbin_d = '0;
      ov_d   = 1'b0;
    end else begin
      if (fwft) begin
        if (!empty && (!ov_q || rd_en)) begin
          re   = 1'b1;
          ov_d = 1'b1;
        end else if (rd_en) begin
          ov_d = 1'b0;
        end
      end else begin
        re = rd_en & ~empty;
      end
      if (re) rbin_d = rbin_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q <= '0;
      rgray  <= '0;
      ov_q   <= 1'b0;
    end else begin
      rbin_q <= rbin_d;
      rgray  <= PW'(bin2gray(32'(rbin_d)));
      ov_q   <= ov_d;
    end
  end

  assign occ_tot = occ + PW'(fwft & ov_q);
  assign aempty  = (occ_tot <= PW'(ae_off));
  assign raddr   = rbin_q[AW-1:0];
  assign rbin    = rbin_q;
  assign ovalid  = ov_q;
endmodule

// File: rtl/xfifo_rt.sv
`timescale 1ns/1ps
module xfifo_rt #(
  parameter int AW = 13,
  parameter int DW = 18
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          retx,
  input  logic          out_en,
  input  logic [AW-1:0] ae_off,
  input  logic [AW-1:0] af_off,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  logic          any_rst_n;
  logic          w_rst_n, w_mrst_n, r_rst_n, r_mrst_n;
  logic          w_we, w_full, w_hfull, w_afull, w_fwft;
  logic [AW-1:0] w_addr, r_addr;
  logic [AW:0]   w_gray, w_bin, r_gray, r_bin;
  logic          r_re, r_empty, r_ovalid, r_aempty, r_fwft;
  logic [DW-1:0] ram_q;

  assign any_rst_n = mrst_n & prst_n;

  xfifo_rst_sync #(.STAGES(2)) u_wrst  (.clk(wr_clk), .arst_n(any_rst_n), .rst_n_o(w_rst_n));
  xfifo_rst_sync #(.STAGES(2)) u_wmrst (.clk(wr_clk), .arst_n(mrst_n),    .rst_n_o(w_mrst_n));
  xfifo_rst_sync #(.STAGES(2)) u_rrst  (.clk(rd_clk), .arst_n(any_rst_n), .rst_n_o(r_rst_n));
  xfifo_rst_sync #(.STAGES(2)) u_rmrst (.clk(rd_clk), .arst_n(mrst_n),    .rst_n_o(r_mrst_n));

  xfifo_wside #(.AW(AW)) u_wside (
    .clk(wr_clk), .rst_n(w_rst_n), .mrst_n(w_mrst_n), .mode_in(fwft_sel),
    .wr_en(wr_en), .rgray_a(r_gray), .af_off(af_off),
    .we(w_we), .waddr(w_addr), .wgray(w_gray), .wbin(w_bin),
    .full(w_full), .hfull(w_hfull), .afull(w_afull), .fwft(w_fwft)
  );

  xfifo_rside #(.AW(AW)) u_rside (
    .clk(rd_clk), .rst_n(r_rst_n), .mrst_n(r_mrst_n), .mode_in(fwft_sel),
    .rd_en(rd_en), .retx(retx), .wgray_a(w_gray), .ae_off(ae_off),
    .re(r_re), .raddr(r_addr), .rgray(r_gray), .rbin(r_bin),
    .empty(r_empty), .ovalid(r_ovalid), .aempty(r_aempty), .fwft(r_fwft)
  );

  xfifo_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wr_clk), .we(w_we), .waddr(w_addr), .wdata(wr_data),
    .rclk(rd_clk), .re(r_re), .raddr(r_addr), .rdata(ram_q)
  );

  assign rd_data      = out_en ? ram_q : 'z;
  assign rd_flag      = r_fwft ? r_ovalid : r_empty;
  assign wr_flag      = w_fwft ? ~w_full : w_full;
  assign half_full    = w_hfull;
  assign almost_full  = w_afull;
  assign almost_empty = r_aempty;
endmodule

// File: rtl/xfifo_rt_chk.sv
`timescale 1ns/1ps
module xfifo_rt_chk #(
  parameter int AW = 13
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        w_rst_n,
  input logic        r_rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        retx,
  input logic        w_full,
  input logic        w_hfull,
  input logic        w_afull,
  input logic [AW:0] w_bin,
  input logic [AW:0] w_gray,
  input logic        r_empty,
  input logic        r_fwft,
  input logic        r_ovalid,
  input logic [AW:0] r_bin,
  input logic [AW:0] r_gray
);
  // R5
  no_write_when_full_chk: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    (w_full && wr_en) |=> (w_bin == $past(w_bin)));

  // R6
  no_read_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (!r_fwft && r_empty && rd_en && !retx) |=> (r_bin == $past(r_bin)));

  // R9
  rewind_to_start_chk: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    retx |=> (r_bin == '0));

  // R7
  full_implies_half_chk: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    w_full |-> (w_hfull && w_afull));

  // R4
  fwft_word_held_chk: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    (r_fwft && r_ovalid && !rd_en && !retx) |=> r_ovalid);

  // R2
  wgray_one_step_chk: assert property (@(posedge wr_clk) disable iff (!w_rst_n)
    1'b1 |=> ($countones(w_gray ^ $past(w_gray)) <= 1));

  // R2
  rgray_one_step_chk: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    !retx |=> ($countones(r_gray ^ $past(r_gray)) <= 1));
endmodule

bind xfifo_rt xfifo_rt_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .wr_en(wr_en), .rd_en(rd_en), .retx(retx),
  .w_full(w_full), .w_hfull(w_hfull), .w_afull(w_afull),
  .w_bin(w_bin), .w_gray(w_gray),
  .r_empty(r_empty), .r_fwft(r_fwft), .r_ovalid(r_ovalid),
  .r_bin(r_bin), .r_gray(r_gray)
);

// File: tb/xfifo_rt_tb_top.sv
`timescale 1ns/1ps
module xfifo_rt_tb_top;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk, rd_clk;
  logic          mrst_n, prst_n, fwft_sel;
  logic          wr_en, rd_en, retx, out_en;
  logic [17:0]   wr_data;
  logic [AW-1:0] ae_off, af_off;
  wire  [17:0]   rd_data;
  logic          rd_flag, wr_flag, half_full, almost_empty, almost_full;

  int n_chk;
  int n_fail;
  logic [17:0] mq[$];
  logic [17:0] hq[$];

  xfifo_rt #(.AW(AW), .DW(18)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .retx(retx), .out_en(out_en), .ae_off(ae_off), .af_off(af_off),
    .rd_data(rd_data), .rd_flag(rd_flag), .wr_flag(wr_flag),
    .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  initial wr_clk = 1'b0;
  always #5 wr_clk = ~wr_clk;
  initial rd_clk = 1'b0;
  always #6.5 rd_clk = ~rd_clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] next_word();
    return 18'($urandom) | 18'h1;
  endfunction

  task automatic settle();
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic do_mreset(input logic mode);
    mrst_n   = 1'b0;
    fwft_sel = mode;
    repeat (4) @(negedge rd_clk);
    mrst_n = 1'b1;
    settle();
    mq.delete();
    hq.delete();
  endtask

  task automatic do_preset();
    @(negedge rd_clk);
    prst_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    prst_n = 1'b1;
    settle();
    mq.delete();
    hq.delete();
  endtask

  task automatic wr_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = next_word();
      mq.push_back(wr_data);
      hq.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_std(input string req);
    logic [17:0] e;
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    e = mq.pop_front();
    chk(rd_data == e, req, "std read word", 32'(rd_data), 32'(e));
  endtask

  task automatic pop_fwft(input string req);
    logic [17:0] e;
    @(negedge rd_clk);
    e = mq.pop_front();
    chk(rd_flag == 1'b1, req, "output valid before pop", 32'(rd_flag), 1);
    chk(rd_data == e, req, "fall-through word", 32'(rd_data), 32'(e));
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic random_phase(input bit fw, input int nwords);
    fork
      begin
        int sent = 0;
        while (sent < nwords) begin
          @(negedge wr_clk);
          if (($urandom % 4 != 0) && (fw ? wr_flag : !wr_flag)) begin
            wr_en   = 1'b1;
            wr_data = next_word();
            mq.push_back(wr_data);
            sent++;
          end else begin
            wr_en = 1'b0;
          end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
      end
      begin
        int got = 0;
        bit pend = 1'b0;
        logic [17:0] expw = '0;
        while (got < nwords) begin
          @(negedge rd_clk);
          if (fw) begin
            rd_en = 1'b0;
            if (rd_flag && ($urandom % 3 != 0)) begin
              expw = mq.pop_front();
              chk(rd_data == expw, "R2", "fall-through random order", 32'(rd_data), 32'(expw));
              rd_en = 1'b1;
              got++;
            end
          end else begin
            if (pend) begin
              chk(rd_data == expw, "R2", "standard random order", 32'(rd_data), 32'(expw));
              got++;
            end
            pend  = 1'b0;
            rd_en = 1'b0;
            if (got < nwords && !rd_flag && ($urandom % 3 != 0)) begin
              rd_en = 1'b1;
              expw  = mq.pop_front();
              pend  = 1'b1;
            end
          end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
      end
    join
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [17:0] w;
    void'($urandom(32'd2718));
    n_chk = 0; n_fail = 0;
    mrst_n = 1'b0; prst_n = 1'b1; fwft_sel = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; retx = 1'b0; out_en = 1'b1;
    wr_data = '0; ae_off = AW'(3); af_off = AW'(4);

    // R1, R11: standard style reset state
    do_mreset(1'b0);
    chk(rd_flag == 1'b1, "R1", "empty after reset", 32'(rd_flag), 1);
    chk(wr_flag == 1'b0, "R1", "full after reset", 32'(wr_flag), 0);
    chk(half_full == 1'b0, "R1", "half full after reset", 32'(half_full), 0);
    chk(almost_empty == 1'b1, "R1", "almost empty after reset", 32'(almost_empty), 1);
    chk(almost_full == 1'b0, "R1", "almost full after reset", 32'(almost_full), 0);

    // R3: first-word latency in standard style
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = next_word(); mq.push_back(wr_data);
    @(posedge wr_clk); #1 wr_en = 1'b0;
    @(posedge rd_clk); #2;
    chk(rd_flag == 1'b1, "R3", "empty after first read edge", 32'(rd_flag), 1);
    @(posedge rd_clk); #2;
    chk(rd_flag == 1'b0, "R3", "not empty after second read edge", 32'(rd_flag), 0);
    pop_std("R3");

    // R6: reads while empty are dropped
    @(negedge rd_clk); rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_en = 1'b0;
    chk(rd_flag == 1'b1, "R6", "still empty after idle reads", 32'(rd_flag), 1);
    wr_burst(1);
    settle();
    pop_std("R6");

    // R7, R8, R5: fill through thresholds
    wr_burst(DEPTH / 2);
    settle();
    chk(half_full == 1'b0, "R7", "half full at exactly half", 32'(half_full), 0);
    chk(almost_empty == 1'b0, "R8", "almost empty at half", 32'(almost_empty), 0);
    wr_burst(1);
    settle();
    chk(half_full == 1'b1, "R7", "half full above half", 32'(half_full), 1);
    wr_burst(DEPTH - 4 - DEPTH / 2 - 2);
    settle();
    chk(almost_full == 1'b0, "R8", "almost full one below", 32'(almost_full), 0);
    wr_burst(1);
    settle();
    chk(almost_full == 1'b1, "R8", "almost full at threshold", 32'(almost_full), 1);
    chk(wr_flag == 1'b0, "R5", "not full before last words", 32'(wr_flag), 0);
    wr_burst(4);
    settle();
    chk(wr_flag == 1'b1, "R5", "full flag at depth", 32'(wr_flag), 1);
    @(negedge wr_clk); wr_en = 1'b1; wr_data = 18'h3ffff;
    repeat (2) @(negedge wr_clk);
    wr_en = 1'b0;
    settle();
    chk(wr_flag == 1'b1, "R5", "full held after dropped writes", 32'(wr_flag), 1);
    for (int i = 0; i < DEPTH - 4; i++) pop_std("R5");
    chk(almost_empty == 1'b0, "R8", "almost empty with four left", 32'(almost_empty), 0);
    pop_std("R5");
    chk(almost_empty == 1'b1, "R8", "almost empty with three left", 32'(almost_empty), 1);
    for (int i = 0; i < 3; i++) pop_std("R5");
    chk(rd_flag == 1'b1, "R5", "empty after depth reads, overflow dropped", 32'(rd_flag), 1);

    // R9: rewind in standard style
    do_mreset(1'b0);
    wr_burst(6);
    settle();
    for (int i = 0; i < 6; i++) pop_std("R9");
    chk(rd_flag == 1'b1, "R9", "empty before rewind", 32'(rd_flag), 1);
    mq = hq;
    @(negedge rd_clk); retx = 1'b1;
    @(negedge rd_clk); retx = 1'b0;
    chk(rd_flag == 1'b0, "R9", "not empty one edge after rewind", 32'(rd_flag), 0);
    for (int i = 0; i < 6; i++) pop_std("R9");

    // R11, R4: fall-through style
    do_mreset(1'b1);
    chk(rd_flag == 1'b0, "R11", "no output valid after reset", 32'(rd_flag), 0);
    chk(wr_flag == 1'b1, "R11", "input ready after reset", 32'(wr_flag), 1);
    @(negedge wr_clk);
    w = next_word();
    wr_en = 1'b1; wr_data = w; mq.push_back(w);
    @(posedge wr_clk); #1 wr_en = 1'b0;
    @(posedge rd_clk); #2;
    chk(rd_flag == 1'b0, "R4", "valid low at first edge", 32'(rd_flag), 0);
    @(posedge rd_clk); #2;
    chk(rd_flag == 1'b0, "R4", "valid low at second edge", 32'(rd_flag), 0);
    @(posedge rd_clk); #2;
    chk(rd_flag == 1'b1, "R4", "valid high at third edge", 32'(rd_flag), 1);
    chk(rd_data == w, "R4", "word shown without read", 32'(rd_data), 32'(w));
    pop_fwft("R4");
    chk(rd_flag == 1'b0, "R4", "valid low after consume", 32'(rd_flag), 0);

    // R12: output enable
    wr_burst(2);
    settle();
    @(negedge rd_clk); out_en = 1'b0;
    #1;
    chk(rd_data !== mq[0], "R12", "data released when disabled", 32'(rd_data), 32'(mq[0]));
    @(negedge rd_clk); rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    void'(mq.pop_front());
    out_en = 1'b1;
    #1;
    chk(rd_data == mq[0], "R12", "read still consumed while disabled", 32'(rd_data), 32'(mq[0]));
    pop_fwft("R12");

    // R10: partial reset keeps fall-through style
    wr_burst(3);
    do_preset();
    chk(rd_flag == 1'b0, "R10", "no valid word after partial reset", 32'(rd_flag), 0);
    chk(wr_flag == 1'b1, "R10", "input ready keeps style", 32'(wr_flag), 1);
    wr_burst(4);
    settle();
    for (int i = 0; i < 4; i++) pop_fwft("R10");

    // R9: rewind in fall-through style
    mq = hq;
    @(negedge rd_clk); retx = 1'b1;
    @(negedge rd_clk); retx = 1'b0;
    chk(rd_flag == 1'b0, "R9", "valid low first edge after rewind", 32'(rd_flag), 0);
    @(negedge rd_clk);
    chk(rd_flag == 1'b1, "R9", "valid high second edge after rewind", 32'(rd_flag), 1);
    chk(rd_data == mq[0], "R9", "first word again", 32'(rd_data), 32'(mq[0]));
    for (int i = 0; i < 4; i++) pop_fwft("R9");

    // R2: random traffic in both styles
    do_mreset(1'b1);
    random_phase(1'b1, 400);
    do_mreset(1'b0);
    random_phase(1'b0, 400);
    settle();
    chk(rd_flag == 1'b1, "R2", "empty after random traffic", 32'(rd_flag), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule